// File: doc/BRIEF.md
# Extended Match Timer Channel Bank

This block holds eight match channels, numbered 4 to 11 (channel index 0 to 7 on the bus). Each channel has a 32-bit counter, a 32-bit match value and a control word. Free-running tick enables come in from outside, one for each rate code. A channel's control word picks which tick advances its own counter.

By default a channel compares against the counter of its group. Channels 4 to 7 use channel 4's counter, 8 and 9 use channel 8's, and 10 and 11 use channel 10's. A control bit switches a channel to its own counter instead. Further control bits select three behaviours: clear the counter on a match, rearm the compare after a match for periodic events, and capture the neighbouring counter into a snapshot when the counter is read. Every match that is enabled sets a status bit, and the status bits together drive one interrupt line.

Software reaches the block through a flat register port. Writes take effect at the clock edge. Reads are combinational from `bus_addr`. A read strobe is only needed for the snapshot side effect.

Top module: `xmatch_bank`

## Requirements
- R1: After reset every counter, match, control, enable, status and snapshot register reads zero and `irq` is low.
- R2: Addressing is `bus_addr[4:3]` = kind (0 match, 1 counter, 2 control, 3 misc) and `bus_addr[2:0]` = channel minus 4. Control words of channels 4 to 7 keep only bits [7:0] and those of channels 8 to 11 keep bits [9:0]. The enable register (misc 1) holds bits [11:4].
- R3: Control bits [2:0] give a rate code c. A counter with code c advances by one on each clock where `tick_en[c]` is high. Code 0 holds the counter and never produces a match. A counter write loads the value at the next edge.
- R4: For channels 5 to 7, a control write changes the channel's rate code only when the written bit 7 is 1. Channel 4 always takes it.
- R5: For channels 9 and 11, the rate code changes only when the written bit 7 is 1. Channels 8 and 10 always take it. When the written bit 8 is 1, the code taken is 0.
- R6: With control bit 7 clear, a channel compares against its group counter (4 for 4 to 7, 8 for 8 and 9, 10 for 10 and 11). With bit 7 set, it compares against its own counter.
- R7: A match happens when the selected counter steps onto the match value. It sets status bit 4+index (misc 0) if the same enable bit is 1. `irq` is high while any status bit is set, starting the cycle after the matching tick.
- R8: Writing 1s to the status register clears those bits. `irq` falls once no bit is left set.
- R9: With control bit 3 set, a match loads the selected counter with zero instead of the match value.
- R10: With control bit 6 set, the compare stays armed after a match. With bit 6 clear, it disarms until the channel's match or control register is written again.
- R11: A read strobe on the counter of channel 9 or 11 whose control bit 9 is set copies the previous channel's counter into the snapshot register (misc 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 8 | Tick enable per rate code |
| bus_addr | input | 5 | Register select, kind and channel |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe, used for snapshot capture |
| rd_data | output | 32 | Read data of the selected register |
| irq | output | 1 | Combined match interrupt |

## Verification
Register writes, counter steps and status updates all land at the edge that samples the strobe, so each result is due one cycle after its stimulus. Every bench task drives inputs at the falling edge, holds them across one rising edge and samples 1 ns after it. `irq` and counter values are therefore read in the first cycle they may change. Reads are combinational, so read data is sampled in the same half cycle its address is driven. A snapshot is checked only after the strobe cycle has closed.

// File: rtl/xm_pkg.sv
package xm_pkg;
  localparam int NCH    = 8;
  localparam int NRATE  = 8;
  localparam int CTRL_W = 10;

  typedef enum logic [1:0] {K_MATCH = 2'd0, K_COUNT = 2'd1, K_CTRL = 2'd2, K_MISC = 2'd3} kind_e;

  // group counter a channel shares when its private bit is clear
  function automatic logic [2:0] group_base(input int idx);
    if (idx < 4)      return 3'd0;
    else if (idx < 6) return 3'd4;
    else              return 3'd6;
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_keep(input int idx, input logic [CTRL_W-1:0] d);
    return (idx < 4) ? {2'b00, d[7:0]} : d;
  endfunction

  function automatic logic rate_takes(input int idx, input logic [CTRL_W-1:0] d);
    if (idx < 4) return d[7] || (idx == 0);
    else         return d[7] || ((idx % 2) == 0);
  endfunction

  function automatic logic [2:0] rate_pick(input int idx, input logic [CTRL_W-1:0] d);
    return (idx >= 4 && d[8]) ? 3'd0 : d[2:0];
  endfunction
endpackage

// File: rtl/xm_counter.sv
module xm_counter #(
  parameter int CW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [xm_pkg::NRATE-1:0] ticks,
  input  logic [2:0]               rate,
  input  logic                     load,
  input  logic [CW-1:0]            load_val,
  input  logic                     clr,
  output logic [CW-1:0]            cnt,
  output logic                     step
);
  assign step = (rate != 3'd0) && ticks[rate];

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/xm_channel.sv
module xm_channel import xm_pkg::*; #(
  parameter int CW  = 32,
  parameter int IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              match_we,
  input  logic [CW-1:0]     wdata,
  input  logic [CW-1:0]     src_cnt,
  input  logic              src_step,
  output logic [CTRL_W-1:0] ctrl,
  output logic [CW-1:0]     match,
  output logic [2:0]        rate,
  output logic              hit
);
  logic armed;

  assign hit = armed && src_step && ((src_cnt + CW'(1)) == match);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl  <= '0;
      match <= '0;
      rate  <= '0;
      armed <= 1'b0;
    end else begin
      if (ctrl_we) begin
        ctrl <= ctrl_keep(IDX, wdata[CTRL_W-1:0]);
        if (rate_takes(IDX, wdata[CTRL_W-1:0]))
          rate <= rate_pick(IDX, wdata[CTRL_W-1:0]);
      end
      if (match_we) match <= wdata;
      if (ctrl_we || match_we)   armed <= 1'b1;
      else if (hit && !ctrl[6])  armed <= 1'b0;
    end
  end
endmodule

// File: rtl/xmatch_bank.sv
module xmatch_bank import xm_pkg::*; #(
  parameter int CW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NRATE-1:0] tick_en,
  input  logic [4:0]       bus_addr,
  input  logic             wr_en,
  input  logic [CW-1:0]    wr_data,
  input  logic             rd_en,
  output logic [CW-1:0]    rd_data,
  output logic             irq
);
  localparam int ST_LSB = 4;

  kind_e       kind;
  logic [2:0]  idx;
  assign kind = kind_e'(bus_addr[4:3]);
  assign idx  = bus_addr[2:0];

  logic [CW-1:0]     cnt_q    [NCH];
  logic [CW-1:0]     match_q  [NCH];
  logic [CTRL_W-1:0] ctrl_q   [NCH];
  logic [2:0]        rate_q   [NCH];
  logic [CW-1:0]     src_cnt  [NCH];
  logic [2:0]        sel      [NCH];
  logic [NCH-1:0]    step_w, src_step, hit_w, clr_w;
  logic [NCH-1:0]    stat_q, en_q;
  logic [CW-1:0]     snap_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    xm_channel #(.CW(CW), .IDX(g)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_we  (wr_en && kind == K_CTRL  && idx == 3'(g)),
      .match_we (wr_en && kind == K_MATCH && idx == 3'(g)),
      .wdata    (wr_data),
      .src_cnt  (src_cnt[g]),
      .src_step (src_step[g]),
      .ctrl     (ctrl_q[g]),
      .match    (match_q[g]),
      .rate     (rate_q[g]),
      .hit      (hit_w[g])
    );
    xm_counter #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .ticks    (tick_en),
      .rate     (rate_q[g]),
      .load     (wr_en && kind == K_COUNT && idx == 3'(g)),
      .load_val (wr_data),
      .clr      (clr_w[g]),
      .cnt      (cnt_q[g]),
      .step     (step_w[g])
    );
  end

  // counter routing: group counter unless the private bit is set
  always_comb begin
    for (int j = 0; j < NCH; j++) begin
      sel[j]      = ctrl_q[j][7] ? 3'(j) : group_base(j);
      src_cnt[j]  = cnt_q[sel[j]];
      src_step[j] = step_w[sel[j]];
    end
  end

  always_comb begin
    clr_w = '0;
    for (int j = 0; j < NCH; j++)
      if (hit_w[j] && ctrl_q[j][3]) clr_w[sel[j]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      snap_q <= '0;
    end else begin
      if (wr_en && kind == K_MISC && idx == 3'd1)
        en_q <= wr_data[ST_LSB +: NCH];
      if (wr_en && kind == K_MISC && idx == 3'd0)
        stat_q <= (stat_q & ~wr_data[ST_LSB +: NCH]) | (hit_w & en_q);
      else
        stat_q <= stat_q | (hit_w & en_q);
      if (rd_en && kind == K_COUNT && idx[2] && idx[0] && ctrl_q[idx][9])
        snap_q <= cnt_q[idx - 3'd1];
    end
  end

  assign irq = |stat_q;

  always_comb begin
    rd_data = '0;
    case (kind)
      K_MATCH: rd_data = match_q[idx];
      K_COUNT: rd_data = cnt_q[idx];
      K_CTRL:  rd_data = CW'(ctrl_q[idx]);
      K_MISC: begin
        case (idx)
          3'd0:    rd_data = CW'({stat_q, 4'b0000});
          3'd1:    rd_data = CW'({en_q, 4'b0000});
          3'd2:    rd_data = snap_q;
          default: rd_data = '0;
        endcase
      end
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/xm_chk.sv
module xm_chk #(
  parameter int CW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           irq,
  input logic [4:0]     bus_addr,
  input logic           wr_en,
  input logic [CW-1:0]  wr_data,
  input logic [7:0]     hit_w,
  input logic [7:0]     src_step,
  input logic [7:0]     en_q,
  input logic [7:0]     stat_q,
  input logic [CW-1:0]  cnt_q [8]
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq && stat_q == 8'h00));

  // R7
  hit_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit_w & en_q)) |=> irq);

  // R3
  stopped_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_w) |-> ((hit_w & ~src_step) == 8'h00));

  // R8
  clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == 5'h18 && wr_data[11:4] == stat_q && hit_w == 8'h00) |=> !irq);

  for (genvar k = 0; k < 8; k++) begin : g_ld
    // R3
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bus_addr == {2'b01, 3'(k)}) |=> (cnt_q[k] == $past(wr_data)));
  end
endmodule

bind xmatch_bank xm_chk #(.CW(CW)) u_chk (.*);

// File: tb/sim_xmatch_bank.sv
`timescale 1ns/100ps
module sim_xmatch_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tick_en = '0;
  logic [4:0]  bus_addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        irq;

  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  xmatch_bank u0 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
                  .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq));

  // {addr, write data, expected read-back}
  localparam logic [68:0] VEC [6] = '{
    {5'h10, 32'h0000_03FF, 32'h0000_00FF},
    {5'h13, 32'hFFFF_FFFF, 32'h0000_00FF},
    {5'h14, 32'h0000_03FF, 32'h0000_03FF},
    {5'h17, 32'hFFFF_FFFF, 32'h0000_03FF},
    {5'h02, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {5'h19, 32'hFFFF_FFFF, 32'h0000_0FF0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; rd_en = 1'b1;
    #1 v = rd_data;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic tick(input int code, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en[code] = 1'b1;
      @(posedge clk); #1 tick_en[code] = 1'b0;
    end
  endtask

  logic [31:0] v;

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(5'h10, v); chk("R1 ctrl4", v, 32'h0);
    rd(5'h0C, v); chk("R1 count8", v, 32'h0);
    rd(5'h18, v); chk("R1 status", v, 32'h0);
    rd(5'h1A, v); chk("R1 snapshot", v, 32'h0);

    // R2 register masks via vector table
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][68:64], VEC[i][63:32]);
      rd(VEC[i][68:64], v);
      chk("R2 readback", v, VEC[i][31:0]);
    end

    // R3 rate select, stop, load
    do_reset();
    wr(5'h10, 32'h01);
    wr(5'h08, 32'd10);
    rd(5'h08, v); chk("R3 load", v, 32'd10);
    tick(2, 3);
    rd(5'h08, v); chk("R3 other code ignored", v, 32'd10);
    tick(1, 3);
    rd(5'h08, v); chk("R3 counts", v, 32'd13);
    wr(5'h10, 32'h00);
    tick(1, 2);
    rd(5'h08, v); chk("R3 code0 holds", v, 32'd13);

    // R4 rate latch for channels 5..7
    do_reset();
    wr(5'h11, 32'h02);
    tick(2, 2);
    rd(5'h09, v); chk("R4 no bit7 keeps rate", v, 32'd0);
    wr(5'h11, 32'h82);
    tick(2, 2);
    rd(5'h09, v); chk("R4 bit7 takes rate", v, 32'd2);

    // R5 rate latch for channels 8..11
    do_reset();
    wr(5'h15, 32'h001);
    tick(1, 1);
    rd(5'h0D, v); chk("R5 odd no bit7", v, 32'd0);
    wr(5'h14, 32'h101);
    tick(1, 1);
    rd(5'h0C, v); chk("R5 bit8 forces 0", v, 32'd0);
    wr(5'h14, 32'h001);
    tick(1, 1);
    rd(5'h0C, v); chk("R5 even takes rate", v, 32'd1);
    wr(5'h15, 32'h181);
    tick(1, 1);
    rd(5'h0D, v); chk("R5 odd bit7 bit8", v, 32'd0);

    // R6 / R7 shared counter, status, irq
    do_reset();
    wr(5'h19, 32'hFF0);
    wr(5'h10, 32'h01);
    wr(5'h00, 32'd100);
    wr(5'h12, 32'h00);
    wr(5'h02, 32'd5);
    tick(1, 4);
    chk("R7 no early irq", {31'b0, irq}, 32'h0);
    tick(1, 1);
    chk("R6 shared match irq", {31'b0, irq}, 32'h1);
    rd(5'h18, v); chk("R7 status bit6", v, 32'h040);
    // R8 clear
    wr(5'h18, 32'h040);
    chk("R8 irq drops", {31'b0, irq}, 32'h0);
    rd(5'h18, v); chk("R8 status cleared", v, 32'h0);

    // R7 enable gating
    do_reset();
    wr(5'h10, 32'h01);
    wr(5'h00, 32'd2);
    tick(1, 2);
    chk("R7 disabled no irq", {31'b0, irq}, 32'h0);
    rd(5'h18, v); chk("R7 disabled no status", v, 32'h0);

    // R8 partial clear
    do_reset();
    wr(5'h19, 32'hFF0);
    wr(5'h10, 32'h01);
    wr(5'h00, 32'd3);
    wr(5'h01, 32'd3);
    tick(1, 3);
    rd(5'h18, v); chk("R7 two status bits", v, 32'h030);
    wr(5'h18, 32'h010);
    chk("R8 irq holds", {31'b0, irq}, 32'h1);
    wr(5'h18, 32'h020);
    chk("R8 irq falls", {31'b0, irq}, 32'h0);

    // R9 reset on match
    do_reset();
    wr(5'h19, 32'hFF0);
    wr(5'h14, 32'h009);
    wr(5'h04, 32'd4);
    tick(1, 4);
    rd(5'h0C, v); chk("R9 counter zeroed", v, 32'd0);
    rd(5'h18, v); chk("R9 status bit8", v, 32'h100);
    tick(1, 1);
    rd(5'h0C, v); chk("R9 counts again", v, 32'd1);

    // R10 periodic vs one-shot
    do_reset();
    wr(5'h19, 32'hFF0);
    wr(5'h10, 32'h49);
    wr(5'h00, 32'd2);
    tick(1, 2);
    chk("R10 first period", {31'b0, irq}, 32'h1);
    wr(5'h18, 32'hFF0);
    tick(1, 2);
    chk("R10 rearmed", {31'b0, irq}, 32'h1);
    do_reset();
    wr(5'h19, 32'hFF0);
    wr(5'h10, 32'h09);
    wr(5'h00, 32'd2);
    tick(1, 2);
    chk("R10 one-shot fires", {31'b0, irq}, 32'h1);
    wr(5'h18, 32'hFF0);
    tick(1, 2);
    chk("R10 one-shot disarmed", {31'b0, irq}, 32'h0);

    // R11 snapshot
    do_reset();
    wr(5'h0C, 32'd77);
    wr(5'h15, 32'h200);
    rd(5'h0D, v);
    rd(5'h1A, v); chk("R11 snapshot taken", v, 32'd77);
    wr(5'h0E, 32'd55);
    rd(5'h0F, v);
    rd(5'h1A, v); chk("R11 no bit9 no capture", v, 32'd77);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule